// File: doc/BRIEF.md
# Subclock Watch Prescaler

This block is a free-running up-counter advanced by a subclock enable pulse. It feeds a set of divided clock taps to peripherals and raises a periodic watch interrupt at a software-selected interval. A small control register, written through a write-enable and a 5-bit data field, provides four controls: a software clear, an interrupt enable, a sticky interrupt flag and a 2-bit interval select.

The same counter times the fixed subclock oscillation-stabilization wait. The wait starts at power-on reset and again whenever the system leaves sub-stop mode. A status output stays high until the wait has run its full count. While that status is high, requests to move the system onto the subclock are refused. When the watchdog is set to count on prescaler ticks, each prescaler clear also drives a one-cycle watchdog-clear pulse. This keeps the watchdog's timing consistent with the restarted taps. A single-clock configuration input switches the whole block off.

Top module: `subclk_prescaler`

## Requirements
- R1: While reset is applied and just after it, taps are 0, irq is 0, wdt_clr is 0 and stabilizing is 1.
- R2: Each cycle with sub_tick high advances the 15-bit counter by one. The output taps[i] carries counter bit 1+i, for i = 0 to 3.
- R3: A write (wr_en high) with wr_data[0] = 0 clears the counter at that clock edge. A write with wr_data[0] = 1 leaves the counter untouched.
- R4: wdt_clr is high during exactly those cycles in which a clear is requested, either by a software clear write or by sub_stop_exit, and only while wdt_src_pre is 1. It stays 0 while wdt_src_pre is 0.
- R5: A sub_stop_exit pulse clears the counter and sets stabilizing. stabilizing falls on the tick that takes the counter from 1023 to 1024. Power-on reset starts the same wait.
- R6: req_denied is high exactly when sub_mode_req is high while stabilizing is 1.
- R7: The flag is set when counter bit 4+2*sel rises, where sel is wr_data[4:3] from the last write. irq is the flag gated by the interrupt enable, wr_data[1].
- R8: While main_stop is high the counter keeps counting, but the flag is not set.
- R9: The flag stays set until a write with wr_data[2] = 0. A write with wr_data[2] = 1 has no effect on it.
- R10: While single_clk is high the counter is held at 0, and irq, stabilizing and wdt_clr are all 0.
- R11: After any clear the taps restart from their low phase. tap 0 first goes high after two ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| sub_tick | input | 1 | Subclock enable, one count per high cycle |
| single_clk | input | 1 | Single-clock configuration; disables the block |
| main_stop | input | 1 | Main stop mode; suppresses the watch interrupt |
| sub_stop_exit | input | 1 | Pulse on leaving sub-stop; restarts the stabilization wait |
| wdt_src_pre | input | 1 | Watchdog counts on prescaler ticks |
| wr_en | input | 1 | Control register write strobe |
| wr_data | input | 5 | Bit 0 clear (active 0), bit 1 enable, bit 2 flag, bits 4:3 interval |
| sub_mode_req | input | 1 | Request to switch the system to the subclock |
| taps | output | 4 | Divided clock taps, counter bits 4:1 |
| irq | output | 1 | Watch interrupt request |
| wdt_clr | output | 1 | Watchdog clear pulse |
| stabilizing | output | 1 | Subclock stabilization wait in progress |
| req_denied | output | 1 | Subclock switch request refused |

## Verification
The interrupt cannot be seen at the ports while main stop is active. To reach that case, the bench enables the interrupt and lets the counter pass a rising edge of the selected bit with main_stop high. It then confirms two things: irq stays low, and the taps show the counter kept running. It then drops main_stop and ticks to the next rising edge, where the flag must appear. The stabilization edge lies more than a thousand ticks out. The bench reaches it by holding sub_tick high for an exact tick count, both from power-on and after a sub-stop exit pulse.

// File: rtl/sp_pkg.sv
`timescale 1ns/1ps
package sp_pkg;
   localparam int CTL_W      = 5;
   localparam int CTL_CLR_N  = 0;
   localparam int CTL_IE     = 1;
   localparam int CTL_FLAG   = 2;
   localparam int CTL_SEL_LO = 3;
   localparam int N_IV       = 4;

   typedef struct packed {
      logic [1:0] sel;
      logic       flag;
      logic       ie;
      logic       clr_n;
   } ctl_wr_t;

   function automatic ctl_wr_t ctl_decode(input logic [CTL_W-1:0] d);
      ctl_wr_t r;
      r.clr_n = d[CTL_CLR_N];
      r.ie    = d[CTL_IE];
      r.flag  = d[CTL_FLAG];
      r.sel   = d[CTL_SEL_LO +: 2];
      return r;
   endfunction
endpackage

// File: rtl/sp_counter.sv
`timescale 1ns/1ps
module sp_counter #(
   parameter int CNT_W    = 15,
   parameter int NTAP     = 4,
   parameter int TAP_LO   = 1,
   parameter int IV_BASE  = 4,
   parameter int IV_STEP  = 2,
   parameter int STAB_BIT = 10
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  tick,
   input  logic                  clr,
   output logic [NTAP-1:0]       taps,
   output logic [sp_pkg::N_IV-1:0] iv_rise,
   output logic                  stab_rise
);
   localparam int IV_TOP = IV_BASE + IV_STEP * (sp_pkg::N_IV - 1);

   if (IV_BASE < 1 || IV_TOP >= CNT_W) begin : g_bad_iv
      $error("interval bits out of counter range");
   end
   if (STAB_BIT < 1 || STAB_BIT >= CNT_W) begin : g_bad_stab
      $error("stabilization bit out of counter range");
   end
   if (TAP_LO + NTAP > CNT_W) begin : g_bad_tap
      $error("taps exceed counter width");
   end

   logic [CNT_W-1:0] cnt_q;
   logic             adv;

   assign adv = tick & ~clr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   cnt_q <= '0;
      else if (clr) cnt_q <= '0;
      else if (adv) cnt_q <= cnt_q + 1'b1;
   end

   for (genvar i = 0; i < NTAP; i++) begin : g_tap
      assign taps[i] = cnt_q[TAP_LO + i];
   end

   for (genvar k = 0; k < sp_pkg::N_IV; k++) begin : g_iv
      localparam int B = IV_BASE + IV_STEP * k;
      assign iv_rise[k] = adv & ~cnt_q[B] & (&cnt_q[B-1:0]);
   end

   assign stab_rise = adv & ~cnt_q[STAB_BIT] & (&cnt_q[STAB_BIT-1:0]);

   p_clear_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (cnt_q == '0));
   p_count_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
      adv |=> (cnt_q == $past(cnt_q) + 1'b1));
   p_hold_still_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick && !clr) |=> $stable(cnt_q));
endmodule

// File: rtl/sp_watch_irq.sv
`timescale 1ns/1ps
module sp_watch_irq (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    hold,
   input  logic [sp_pkg::N_IV-1:0] iv_rise,
   input  logic [1:0]              sel,
   input  logic                    main_stop,
   input  logic                    sw_flag_clr,
   output logic                    flag
);
   logic set_req;

   assign set_req = iv_rise[sel] & ~main_stop;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           flag <= 1'b0;
      else if (hold)        flag <= 1'b0;
      else if (set_req)     flag <= 1'b1;
      else if (sw_flag_clr) flag <= 1'b0;
   end

   p_stop_noset_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (main_stop && !flag) |=> !flag);
   p_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (flag && !sw_flag_clr && !hold) |=> flag);
endmodule

// File: rtl/sp_stab.sv
`timescale 1ns/1ps
module sp_stab (
   input  logic clk,
   input  logic rst_n,
   input  logic hold,
   input  logic start,
   input  logic done_rise,
   output logic busy
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         busy <= 1'b1;
      else if (hold)      busy <= 1'b0;
      else if (start)     busy <= 1'b1;
      else if (done_rise) busy <= 1'b0;
   end

   p_stab_fall_r5: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(busy) && !$past(hold)) |-> $past(done_rise));
   p_stab_start_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !hold) |=> busy);
endmodule

// File: rtl/subclk_prescaler.sv
`timescale 1ns/1ps
module subclk_prescaler #(
   parameter int CNT_W    = 15,
   parameter int NTAP     = 4,
   parameter int TAP_LO   = 1,
   parameter int IV_BASE  = 4,
   parameter int IV_STEP  = 2,
   parameter int STAB_BIT = 10
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     sub_tick,
   input  logic                     single_clk,
   input  logic                     main_stop,
   input  logic                     sub_stop_exit,
   input  logic                     wdt_src_pre,
   input  logic                     wr_en,
   input  logic [sp_pkg::CTL_W-1:0] wr_data,
   input  logic                     sub_mode_req,
   output logic [NTAP-1:0]          taps,
   output logic                     irq,
   output logic                     wdt_clr,
   output logic                     stabilizing,
   output logic                     req_denied
);
   import sp_pkg::*;

   ctl_wr_t           wr;
   logic              ie_q;
   logic [1:0]        sel_q;
   logic              sw_clr, clr_req, cnt_clr, flag;
   logic [N_IV-1:0]   iv_rise;
   logic              stab_rise;

   assign wr      = ctl_decode(wr_data);
   assign sw_clr  = wr_en & ~wr.clr_n;
   assign clr_req = sw_clr | sub_stop_exit;
   assign cnt_clr = single_clk | clr_req;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ie_q  <= 1'b0;
         sel_q <= '0;
      end else if (wr_en) begin
         ie_q  <= wr.ie;
         sel_q <= wr.sel;
      end
   end

   sp_counter #(
      .CNT_W(CNT_W), .NTAP(NTAP), .TAP_LO(TAP_LO),
      .IV_BASE(IV_BASE), .IV_STEP(IV_STEP), .STAB_BIT(STAB_BIT)
   ) u_cnt (
      .clk(clk), .rst_n(rst_n), .tick(sub_tick), .clr(cnt_clr),
      .taps(taps), .iv_rise(iv_rise), .stab_rise(stab_rise)
   );

   sp_watch_irq u_irq (
      .clk(clk), .rst_n(rst_n), .hold(single_clk), .iv_rise(iv_rise),
      .sel(sel_q), .main_stop(main_stop),
      .sw_flag_clr(wr_en & ~wr.flag), .flag(flag)
   );

   sp_stab u_stab (
      .clk(clk), .rst_n(rst_n), .hold(single_clk), .start(sub_stop_exit),
      .done_rise(stab_rise), .busy(stabilizing)
   );

   assign irq        = flag & ie_q & ~single_clk;
   assign wdt_clr    = wdt_src_pre & ~single_clk & clr_req;
   assign req_denied = sub_mode_req & stabilizing;

   p_wdt_taps_r4: assert property (@(posedge clk) disable iff (!rst_n)
      wdt_clr |=> (taps == '0));
   p_single_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
      single_clk |=> (taps == '0 && !irq && !stabilizing));
   p_deny_needs_wait_r6: assert property (@(posedge clk) disable iff (!rst_n)
      req_denied |-> !$rose(stabilizing) || $past(sub_stop_exit));
endmodule

// File: tb/subclk_prescaler_test.sv
`timescale 1ns/1ps
module subclk_prescaler_test;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       sub_tick = 1'b0, single_clk = 1'b0, main_stop = 1'b0;
   logic       sub_stop_exit = 1'b0, wdt_src_pre = 1'b1, wr_en = 1'b0;
   logic [4:0] wr_data = '0;
   logic       sub_mode_req = 1'b0;
   logic [3:0] taps;
   logic       irq, wdt_clr, stabilizing, req_denied;
   logic       last_wdt;
   int         n_chk = 0, n_bad = 0;
   bit         done = 0;

   always #2 clk = ~clk;

   subclk_prescaler #(.CNT_W(15), .NTAP(4), .TAP_LO(1), .IV_BASE(4),
                      .IV_STEP(2), .STAB_BIT(10)) uut (
      .clk(clk), .rst_n(rst_n), .sub_tick(sub_tick), .single_clk(single_clk),
      .main_stop(main_stop), .sub_stop_exit(sub_stop_exit),
      .wdt_src_pre(wdt_src_pre), .wr_en(wr_en), .wr_data(wr_data),
      .sub_mode_req(sub_mode_req), .taps(taps), .irq(irq), .wdt_clr(wdt_clr),
      .stabilizing(stabilizing), .req_denied(req_denied)
   );

   // {ticks after clear, expected taps}
   localparam int VEC [0:7][0:1] = '{
      '{0, 0}, '{1, 0}, '{2, 1}, '{3, 1},
      '{7, 3}, '{31, 15}, '{32, 0}, '{45, 6}
   };

   task automatic check(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   function automatic logic [4:0] mk(input logic clr_n, input logic ie,
                                     input logic flg, input logic [1:0] sel);
      return {sel, flg, ie, clr_n};
   endfunction

   task automatic ticks(input int n);
      sub_tick = 1'b1;
      repeat (n) @(negedge clk);
      sub_tick = 1'b0;
   endtask

   task automatic wr(input logic [4:0] d);
      wr_data = d;
      wr_en = 1'b1;
      #1 last_wdt = wdt_clr;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      check("R1 taps", taps, 0);
      check("R1 irq", irq, 0);
      check("R1 stabilizing", stabilizing, 1);
      check("R1 wdt_clr", wdt_clr, 0);
      rst_n = 1'b1;
      @(negedge clk);
      // power-on stabilization wait
      sub_mode_req = 1'b1;
      #1 check("R6 denied in wait", req_denied, 1);
      ticks(1023);
      check("R5 still waiting at 1023", stabilizing, 1);
      ticks(1);
      check("R5 done at 1024", stabilizing, 0);
      check("R6 granted after wait", req_denied, 0);
      sub_mode_req = 1'b0;

      // table of counts after a software clear
      for (int v = 0; v < 8; v++) begin
         wr(mk(0, 0, 0, 0));
         check("R4 wdt_clr on sw clear", last_wdt, 1);
         check("R11 taps low after clear", taps, 0);
         ticks(VEC[v][0]);
         check("R2 taps after ticks", taps, VEC[v][1]);
      end

      // clear bit written 1 keeps the count
      wr(mk(0, 0, 0, 0));
      ticks(10);
      wr(mk(1, 0, 0, 0));
      check("R3 no clear on bit0=1", taps, 5);
      check("R4 no wdt_clr without clear", last_wdt, 0);
      ticks(2);
      check("R3 count resumes", taps, 6);

      // interrupt on bit 4 (sel 0)
      wr(mk(0, 1, 0, 0));
      ticks(15);
      check("R7 no irq before bit4", irq, 0);
      ticks(1);
      check("R7 irq at bit4 rise", irq, 1);
      ticks(20);
      check("R9 flag sticky", irq, 1);
      wr(mk(1, 0, 1, 0));
      check("R7 enable gates irq", irq, 0);
      wr(mk(1, 1, 1, 0));
      check("R9 write flag=1 ignored", irq, 1);
      wr(mk(1, 1, 0, 0));
      check("R9 write flag=0 clears", irq, 0);

      // interrupt on bit 8 (sel 2)
      wr(mk(0, 1, 0, 2));
      ticks(255);
      check("R7 sel2 no irq at 255", irq, 0);
      ticks(1);
      check("R7 sel2 irq at 256", irq, 1);

      // main stop: counting continues, flag held off
      wr(mk(0, 1, 0, 0));
      main_stop = 1'b1;
      ticks(40);
      check("R8 no irq in main stop", irq, 0);
      check("R8 counter runs in main stop", taps, 4);
      main_stop = 1'b0;
      ticks(8);
      check("R8 irq after main stop", irq, 1);

      // watchdog source off
      wdt_src_pre = 1'b0;
      wr(mk(0, 0, 0, 0));
      check("R4 no wdt_clr when src off", last_wdt, 0);
      wdt_src_pre = 1'b1;

      // sub-stop exit restarts the wait
      ticks(9);
      sub_stop_exit = 1'b1;
      #1 last_wdt = wdt_clr;
      @(negedge clk);
      sub_stop_exit = 1'b0;
      check("R4 wdt_clr on sub-stop exit", last_wdt, 1);
      check("R5 counter cleared by exit", taps, 0);
      check("R5 wait restarted", stabilizing, 1);
      sub_mode_req = 1'b1;
      #1 check("R6 denied after exit", req_denied, 1);
      ticks(1023);
      check("R5 exit wait at 1023", stabilizing, 1);
      ticks(1);
      check("R5 exit wait done", stabilizing, 0);
      sub_mode_req = 1'b0;

      // single-clock configuration
      wr(mk(1, 1, 0, 0));
      single_clk = 1'b1;
      ticks(20);
      check("R10 taps held", taps, 0);
      check("R10 irq off", irq, 0);
      check("R10 stabilizing off", stabilizing, 0);
      wr(mk(0, 1, 0, 0));
      check("R10 no wdt_clr", last_wdt, 0);
      single_clk = 1'b0;
      ticks(2);
      check("R11 tap0 high after two ticks", taps, 1);

      finish_run();
   end
endmodule